// File: doc/BRIEF.md
# Quarter-Phase SCL Timing Generator

This block derives the serial clock timing of an I2C master from its module clock. A 6-bit selector picks one divisor out of a fixed 64-entry lookup; the lookup is split into two halves with different scaling, so the divisor does not grow monotonically with the selector. One full SCL period lasts exactly the chosen number of module clock cycles. SCL frequency is therefore the module clock divided by that divisor. For example, a 25 MHz module clock and a 400 kHz target need a divisor of at least 62.5, and the nearest entry is 64 at selector 0x2A.

The period is cut into four phases. A one-cycle tick marks every phase boundary, and a 2-bit phase number goes with it, so a bit engine can place SCL edges, SDA changes and sampling points. The divisor is captured only while the enable is low. A selector change made while the generator runs has no effect until the enable is dropped.

Top module: `scl_tick_gen`

## Requirements
- R1: With `divIdx[5]`=0, selectors 0 through 31 give, in selector order, the divisors 30, 32, 36, 42, 48, 52, 60, 72, 80, 88, 104, 128, 144, 160, 192, 240, 288, 320, 384, 480, 576, 640, 768, 960, 1152, 1280, 1536, 1920, 2304, 2560, 3072, 3840.
- R2: With `divIdx[5]`=1, selectors 32 through 63 give, in selector order, the divisors 22, 24, 26, 28, 32, 36, 40, 44, 48, 56, 64, 72, 80, 96, 112, 128, 160, 192, 224, 256, 320, 384, 448, 512, 640, 768, 896, 1024, 1280, 1536, 1792, 2048.
- R3: For a divisor D with Q = D/4 (rounded down), phases 0, 1 and 2 each last Q cycles and phase 3 lasts Q + (D mod 4) cycles. `qTick` is high for one cycle on the first cycle of each new phase. While enabled, the n-th rising edge of `clk` after `en` goes high produces `qTick` when n mod D is 0, Q, 2Q or 3Q.
- R4: `phase` steps 0, 1, 2, 3, 0 and changes only together with `qTick` while enabled. `sclHigh` is 0 in phases 0 and 1 and 1 in phases 2 and 3.
- R5: `sampleStb` is high only on the tick that enters phase 3. `sdaWin` is high exactly while `phase` is 0.
- R6: While `en` is low, the phase is held at 0 and no tick is produced. The first tick after enabling comes Q cycles later.
- R7: The divisor is loaded from `divIdx` on every clock edge where `en` is low. While `en` is high, changes on `divIdx` do not affect tick spacing.
- R8: After reset, `phase` is 0 and `qTick`, `sampleStb` and `sclHigh` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low also loads the divisor |
| divIdx | input | 6 | Divisor selector |
| qTick | output | 1 | One-cycle strobe at each phase boundary |
| phase | output | 2 | Current quarter of the SCL period |
| sclHigh | output | 1 | Wanted SCL level (1 = released high) |
| sdaWin | output | 1 | SDA may change (phase 0) |
| sampleStb | output | 1 | SDA sample point (entry to phase 3) |

## Verification
The checker watches every cycle for the following:
- the phase steps by exactly one on each tick and holds still between ticks;
- an idle generator stays in phase 0 with no tick;
- SCL moves only on a tick;
- the sample strobe lines up with entry to phase 3;
- ticks are never closer together than the shortest phase.

These properties cannot tell whether the right divisor came out of the lookup, or whether phase 3 absorbs the remainder. Only the bench scenarios show this, by matching exact tick positions against D for selected entries in both halves, and by changing the selector mid-run.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  localparam int IDX_W = 6;
  localparam int DIV_W = 12;

  typedef struct packed {
    logic load;
    logic clear;
    logic step;
  } divStrobes_t;

  function automatic logic [DIV_W-1:0] lookupDiv(input logic [IDX_W-1:0] idx);
    logic [DIV_W-1:0] d;
    if (!idx[5]) begin
      case (idx[4:0])
        5'd0:  d = 12'd30;   5'd1:  d = 12'd32;   5'd2:  d = 12'd36;   5'd3:  d = 12'd42;
        5'd4:  d = 12'd48;   5'd5:  d = 12'd52;   5'd6:  d = 12'd60;   5'd7:  d = 12'd72;
        5'd8:  d = 12'd80;   5'd9:  d = 12'd88;   5'd10: d = 12'd104;  5'd11: d = 12'd128;
        5'd12: d = 12'd144;  5'd13: d = 12'd160;  5'd14: d = 12'd192;  5'd15: d = 12'd240;
        5'd16: d = 12'd288;  5'd17: d = 12'd320;  5'd18: d = 12'd384;  5'd19: d = 12'd480;
        5'd20: d = 12'd576;  5'd21: d = 12'd640;  5'd22: d = 12'd768;  5'd23: d = 12'd960;
        5'd24: d = 12'd1152; 5'd25: d = 12'd1280; 5'd26: d = 12'd1536; 5'd27: d = 12'd1920;
        5'd28: d = 12'd2304; 5'd29: d = 12'd2560; 5'd30: d = 12'd3072; default: d = 12'd3840;
      endcase
    end else begin
      case (idx[4:0])
        5'd0:  d = 12'd22;   5'd1:  d = 12'd24;   5'd2:  d = 12'd26;   5'd3:  d = 12'd28;
        5'd4:  d = 12'd32;   5'd5:  d = 12'd36;   5'd6:  d = 12'd40;   5'd7:  d = 12'd44;
        5'd8:  d = 12'd48;   5'd9:  d = 12'd56;   5'd10: d = 12'd64;   5'd11: d = 12'd72;
        5'd12: d = 12'd80;   5'd13: d = 12'd96;   5'd14: d = 12'd112;  5'd15: d = 12'd128;
        5'd16: d = 12'd160;  5'd17: d = 12'd192;  5'd18: d = 12'd224;  5'd19: d = 12'd256;
        5'd20: d = 12'd320;  5'd21: d = 12'd384;  5'd22: d = 12'd448;  5'd23: d = 12'd512;
        5'd24: d = 12'd640;  5'd25: d = 12'd768;  5'd26: d = 12'd896;  5'd27: d = 12'd1024;
        5'd28: d = 12'd1280; 5'd29: d = 12'd1536; 5'd30: d = 12'd1792; default: d = 12'd2048;
      endcase
    end
    return d;
  endfunction
endpackage

// File: rtl/scl_div_dp.sv
module scl_div_dp
  import scl_div_pkg::*;
#(
  parameter int CNT_W = DIV_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  divStrobes_t       stb,
  input  logic [IDX_W-1:0]  divIdx,
  input  logic [1:0]        phase,
  output logic              atEnd
);
  logic [CNT_W-1:0] divReg;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] quarter;
  logic [CNT_W-1:0] phaseLen;

  // Phase 3 absorbs the remainder so the four phases sum to the divisor.
  always_comb begin
    quarter  = divReg >> 2;
    phaseLen = (phase == 2'd3) ? quarter + {{(CNT_W-2){1'b0}}, divReg[1:0]} : quarter;
    atEnd    = (cnt == phaseLen - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg <= CNT_W'(lookupDiv('0));
      cnt    <= '0;
    end else begin
      if (stb.load) divReg <= CNT_W'(lookupDiv(divIdx));
      if (stb.clear)     cnt <= '0;
      else if (stb.step) cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/scl_div_ctrl.sv
module scl_div_ctrl
  import scl_div_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        en,
  input  logic        atEnd,
  output divStrobes_t stb,
  output logic [1:0]  phase,
  output logic        tick
);
  always_comb begin
    stb.load  = !en;
    stb.clear = !en || atEnd;
    stb.step  = en && !atEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= 2'd0;
      tick  <= 1'b0;
    end else if (!en) begin
      phase <= 2'd0;
      tick  <= 1'b0;
    end else if (atEnd) begin
      phase <= phase + 2'd1;
      tick  <= 1'b1;
    end else begin
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/scl_tick_gen.sv
module scl_tick_gen
  import scl_div_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic [IDX_W-1:0] divIdx,
  output logic             qTick,
  output logic [1:0]       phase,
  output logic             sclHigh,
  output logic             sdaWin,
  output logic             sampleStb
);
  divStrobes_t stb;
  logic        atEnd;

  scl_div_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .en(en), .atEnd(atEnd),
    .stb(stb), .phase(phase), .tick(qTick)
  );

  scl_div_dp #(.CNT_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .divIdx(divIdx),
    .phase(phase), .atEnd(atEnd)
  );

  assign sclHigh   = phase[1];
  assign sdaWin    = (phase == 2'd0);
  assign sampleStb = qTick && (phase == 2'd3);
endmodule

// File: rtl/scl_tick_gen_chk.sv
module scl_tick_gen_chk (
  input logic       clk,
  input logic       rstN,
  input logic       en,
  input logic       qTick,
  input logic [1:0] phase,
  input logic       sclHigh,
  input logic       sampleStb
);
  logic [3:0] gap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              gap <= '0;
    else if (!en || qTick)  gap <= '0;
    else if (gap != 4'hF)   gap <= gap + 4'd1;
  end

  p_phase_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    qTick |-> phase == $past(phase) + 2'd1);

  p_phase_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(en) && !qTick) |-> phase == $past(phase));

  p_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(en) |-> (phase == 2'd0 && !qTick));

  p_scl_on_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(en) && !$stable(sclHigh)) |-> qTick);

  p_sample_point_r5: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |-> (qTick && $past(phase) == 2'd2));

  p_min_spacing_r3: assert property (@(posedge clk) disable iff (!rstN)
    qTick |-> gap >= 4'd4);
endmodule

bind scl_tick_gen scl_tick_gen_chk u_chk (
  .clk(clk), .rstN(rstN), .en(en), .qTick(qTick), .phase(phase),
  .sclHigh(sclHigh), .sampleStb(sampleStb)
);

// File: tb/sim_scl_tick_gen.sv
module sim_scl_tick_gen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       en = 1'b0;
  logic [5:0] divIdx = 6'd0;
  logic       qTick, sclHigh, sdaWin, sampleStb;
  logic [1:0] phase;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  localparam int NV = 9;
  localparam logic [5:0] V_IDX [NV] = '{6'h00, 6'h03, 6'h0B, 6'h1F, 6'h20, 6'h21, 6'h2A, 6'h3F, 6'h05};
  localparam int         V_DIV [NV] = '{30, 42, 128, 3840, 22, 24, 64, 2048, 52};

  always #5 clk = ~clk;

  scl_tick_gen u0 (
    .clk(clk), .rstN(rstN), .en(en), .divIdx(divIdx), .qTick(qTick),
    .phase(phase), .sclHigh(sclHigh), .sdaWin(sdaWin), .sampleStb(sampleStb)
  );

  task automatic check(input string tag, input logic ok, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Checks edges startEdge+1 .. startEdge+edges against divisor div.
  task automatic runAndCheck(input int div, input int startEdge, input int edges, input string tag);
    int q = div / 4;
    int bad = 0;
    int actF = 0;
    int expF = 0;
    for (int n = startEdge + 1; n <= startEdge + edges; n++) begin
      int m;
      logic eTick;
      logic [1:0] ePh;
      @(posedge clk);
      @(negedge clk);
      m = n % div;
      eTick = (m == 0) || (m == q) || (m == 2*q) || (m == 3*q);
      ePh = (m < q) ? 2'd0 : (m < 2*q) ? 2'd1 : (m < 3*q) ? 2'd2 : 2'd3;
      if (qTick !== eTick || phase !== ePh || sclHigh !== ePh[1] ||
          sdaWin !== (ePh == 2'd0) || sampleStb !== (eTick && ePh == 2'd3)) begin
        if (bad == 0) begin
          actF = {qTick, phase, sclHigh, sdaWin, sampleStb};
          expF = {eTick, ePh, ePh[1], ePh == 2'd0, eTick && ePh == 2'd3};
        end
        bad++;
      end
    end
    check(tag, bad == 0, actF, expF);
  endtask

  task automatic startWith(input logic [5:0] idx);
    en = 1'b0;
    divIdx = idx;
    @(negedge clk);
    en = 1'b1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 reset outputs", phase == 2'd0 && !qTick && !sampleStb && !sclHigh,
          {phase, qTick, sampleStb, sclHigh}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // Vector walk: R1 (lower half) and R2 (upper half), pattern per R3/R4/R5
    for (int v = 0; v < NV; v++) begin
      startWith(V_IDX[v]);
      runAndCheck(V_DIV[v], 0, 2 * V_DIV[v] + 3, V_IDX[v][5] ? "R2 upper-half divisor" : "R1 lower-half divisor");
    end

    // R6: disabled holds phase 0 with no ticks
    en = 1'b0;
    begin
      int seen = 0;
      for (int k = 0; k < 100; k++) begin
        @(negedge clk);
        if (qTick || phase != 2'd0) seen++;
      end
      check("R6 idle no tick", seen == 0, seen, 0);
    end

    // R6/R3: first tick Q cycles after enable (30 -> Q=7, phase 3 lasts 9)
    startWith(6'h00);
    runAndCheck(30, 0, 7, "R6 first tick after Q");
    runAndCheck(30, 7, 30, "R3 remainder in phase 3");

    // R7: index change while running is ignored
    divIdx = 6'h1F;
    runAndCheck(30, 37, 90, "R7 index ignored while enabled");

    // R7: dropping enable loads the new index
    startWith(6'h20);
    runAndCheck(22, 0, 50, "R7 reload when idle");

    // R5: sample strobe and SDA window on a 24 divisor
    startWith(6'h21);
    runAndCheck(24, 0, 48, "R5 sample and SDA window");

    // R8: reset mid-run returns to the reset state
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R8 async reset", phase == 2'd0 && !qTick && !sclHigh, {phase, qTick, sclHigh}, 0);
    en = 1'b0;
    @(negedge clk);
    rstN = 1'b1;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule